// File: doc/BRIEF.md
# Double-Data-Rate Burst SRAM Command Front End

This block is the synchronous command front end of a common-I/O SRAM that moves two data words per clock cycle. A small parameterised behavioural memory array sits behind it. On every rising clock edge it samples an external pair address, a primary enable (active low), two selectable-polarity bank selects with their static polarity straps, a burst-next input and a write-enable input (active low). From these it decides whether the cycle is a bank-off, an idle, a read, a write, or a continuation of the previous access. Each access moves a fixed pair of words. The lowest word-address bit is never an input: the first beat always goes to word 0 of the pair and the second beat to word 1.

Reads return their pair one cycle after the command: the word-0 beat is shown while the clock is high and the word-1 beat while it is low. Writes use late-write timing. The word-0 beat is captured on the rising edge one cycle after the command and the word-1 beat on the falling edge that follows. Completed writes pass through a two-entry write buffer before they reach the array, and reads look through the in-flight capture and the buffer so that they always see the newest data. The block also drives a data-bus enable and an echo-clock enable, each with its own release rule.

The command state machine has six states. BANK_OFF is entered when the bank selects do not qualify. IDLE is entered when the primary enable is high. RD and WR are entered when a new address is loaded, and RD_CONT and WR_CONT when a burst continues. With burst_next low the next state depends only on the inputs. With burst_next high, BANK_OFF and IDLE stay where they are, RD and RD_CONT go to RD_CONT, and WR and WR_CONT go to WR_CONT. Reset enters IDLE.

Top module: `ddr_burst_sram`

## Requirements
- R1: The bank is qualified only when bank_sel_a_i equals bank_pol_a_i and bank_sel_b_i equals bank_pol_b_i. With burst_next_i low and the bank qualified: ce_n_i high gives IDLE; ce_n_i low with we_n_i low gives a write; ce_n_i low with we_n_i high gives a read. A write requested while ce_n_i is high stores nothing.
- R2: After a read command sampled at rising edge k, dq_oe_o is high from edge k+1 to edge k+2. During that cycle dq_o carries word 0 of the pair (internal low bit 0) while clk is high and word 1 (internal low bit 1) while clk is low.
- R3: For a write command sampled at edge k, dq_i is captured at rising edge k+1 as word 0 and at the falling edge that follows as word 1 of the addressed pair.
- R4: With burst_next_i high after a read or write, the same operation continues at the base pair address with its bit 0 inverted. Each further continue inverts that bit again, so a second continue returns to the base pair.
- R5: With burst_next_i high after BANK_OFF or IDLE, the block stays in that state: no data is stored and the bus stays released, whatever ce_n_i and we_n_i are.
- R6: dq_oe_o is low for the cycle after a bank-off, idle, write or write-continue command.
- R7: cq_oe_o is low for the cycle after a bank-off command or its continuation. It is high after idle, read and write commands.
- R8: A read returns the newest data for its pair even when the write was the command just before it, or is still held in the write buffer.
- R9: The write buffer holds the two most recent completed writes. When a third write completes, the oldest entry goes to the array, and every pair remains readable with its last written data.
- R10: While rst is high the block enters IDLE, drives dq_oe_o low and cq_oe_o high, and empties the write buffer.
- R11: All four polarity strap settings work: for each one, only the matching combination of select levels starts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands on rising edge, DDR data on both edges |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | log2(DEPTH)-1 | External pair address (word address without its lowest bit) |
| ce_n_i | input | 1 | Primary enable, active low |
| bank_sel_a_i | input | 1 | First bank select |
| bank_sel_b_i | input | 1 | Second bank select |
| bank_pol_a_i | input | 1 | Static strap: level at which bank_sel_a_i qualifies |
| bank_pol_b_i | input | 1 | Static strap: level at which bank_sel_b_i qualifies |
| burst_next_i | input | 1 | Low loads a new command; high continues the previous one |
| we_n_i | input | 1 | Low selects write, high selects read, on a new command |
| dq_i | input | DW | Write data, sampled on both clock edges |
| dq_o | output | DW | Read data, word 0 while clk high, word 1 while clk low |
| dq_oe_o | output | 1 | Data bus drive enable |
| cq_oe_o | output | 1 | Echo clock drive enable |

## Verification
The hardest case to reach is a read that must be served from the write path rather than the array. The pair may be only half captured in the cycle it is needed, or held in the second buffer slot just as a new write pushes it into the array. The stimulus reaches both cases by issuing a write immediately followed by a read of the same pair. It also issues runs of four distinct writes and then reads them all back, so that entries are read from the capture registers, from both buffer slots and from the array just after retirement. Every pair is first filled by burst writes and then read back with two continues, so the wrap path is covered across the whole array.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;

    typedef enum logic [2:0] {
        ST_BANK_OFF = 3'd0,
        ST_IDLE     = 3'd1,
        ST_RD       = 3'd2,
        ST_RD_CONT  = 3'd3,
        ST_WR       = 3'd4,
        ST_WR_CONT  = 3'd5
    } dsr_state_e;

    function automatic logic st_is_read(input dsr_state_e s);
        return (s == ST_RD) || (s == ST_RD_CONT);
    endfunction

    function automatic logic st_is_write(input dsr_state_e s);
        return (s == ST_WR) || (s == ST_WR_CONT);
    endfunction

endpackage

// File: rtl/dsr_cmd_fsm.sv
module dsr_cmd_fsm
    import ddr_sram_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          ce_n_i,
    input  logic          bank_sel_a_i,
    input  logic          bank_sel_b_i,
    input  logic          bank_pol_a_i,
    input  logic          bank_pol_b_i,
    input  logic          burst_next_i,
    input  logic          we_n_i,
    output dsr_state_e    state_o,
    output logic [AW-1:0] pair_addr_o
);

    dsr_state_e    state_q, state_d;
    logic [AW-1:0] base_q, base_d;
    logic          flip_q, flip_d;
    logic          qual_w;

    assign qual_w = (bank_sel_a_i == bank_pol_a_i) && (bank_sel_b_i == bank_pol_b_i);

    // next-state decode
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        flip_d  = flip_q;
        if (!burst_next_i) begin
            flip_d = 1'b0;
            if (!qual_w) begin
                state_d = ST_BANK_OFF;
            end else if (ce_n_i) begin
                state_d = ST_IDLE;
            end else begin
                base_d  = addr_i;
                state_d = we_n_i ? ST_RD : ST_WR;
            end
        end else begin
            unique case (state_q)
                ST_BANK_OFF: state_d = ST_BANK_OFF;
                ST_IDLE:     state_d = ST_IDLE;
                ST_RD, ST_RD_CONT: begin
                    state_d = ST_RD_CONT;
                    flip_d  = ~flip_q;
                end
                ST_WR, ST_WR_CONT: begin
                    state_d = ST_WR_CONT;
                    flip_d  = ~flip_q;
                end
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            flip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            flip_q  <= flip_d;
        end
    end

    // outputs
    always_comb begin
        state_o     = state_q;
        pair_addr_o = base_q ^ {{(AW-1){1'b0}}, flip_q};
    end

    p_bank_off_r1: assert property (@(posedge clk) disable iff (rst)
        (!burst_next_i && !qual_w) |=> (state_q == ST_BANK_OFF))
        else $error("bank-off decode");

    p_write_load_r1: assert property (@(posedge clk) disable iff (rst)
        (!burst_next_i && qual_w && !ce_n_i && !we_n_i) |=> (state_q == ST_WR && !flip_q))
        else $error("write decode");

    p_cont_invert_r4: assert property (@(posedge clk) disable iff (rst)
        (burst_next_i && (st_is_read(state_q) || st_is_write(state_q)))
        |=> (flip_q != $past(flip_q)))
        else $error("continue must invert pair bit");

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (burst_next_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE))
        else $error("continue after idle left idle");

    p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (burst_next_i && state_q == ST_BANK_OFF) |=> (state_q == ST_BANK_OFF))
        else $error("continue after bank-off left bank-off");

endmodule

// File: rtl/dsr_store.sv
module dsr_store
    import ddr_sram_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 8,
    parameter int WB_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  dsr_state_e      state_i,
    input  logic [AW-1:0]   pair_addr_i,
    input  logic [DW-1:0]   dq_i,
    output logic [2*DW-1:0] rd_pair_o
);

    localparam int PAIRS = 1 << AW;
    localparam int PW    = 2 * DW;

    // late-write capture stage
    logic          cap_v_q;
    logic [AW-1:0] cap_addr_q;
    logic [DW-1:0] cap_lo_q;
    logic [DW-1:0] cap_hi_q;

    // write buffer, slot 0 newest
    logic [WB_DEPTH-1:0] buf_v_q;
    logic [AW-1:0]       buf_addr_q [WB_DEPTH];
    logic [PW-1:0]       buf_data_q [WB_DEPTH];
    logic [WB_DEPTH-1:0] hit_w;

    logic [PW-1:0] mem [PAIRS];
    logic          push_w;
    logic          retire_w;

    assign push_w   = cap_v_q;
    assign retire_w = push_w && buf_v_q[WB_DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_v_q <= 1'b0;
        end else begin
            cap_v_q <= st_is_write(state_i);
        end
        if (st_is_write(state_i)) begin
            cap_addr_q <= pair_addr_i;
            cap_lo_q   <= dq_i;
        end
    end

    always_ff @(negedge clk) begin
        if (cap_v_q) begin
            cap_hi_q <= dq_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_v_q <= '0;
        end else if (push_w) begin
            for (int i = WB_DEPTH - 1; i > 0; i--) begin
                buf_v_q[i]    <= buf_v_q[i-1];
                buf_addr_q[i] <= buf_addr_q[i-1];
                buf_data_q[i] <= buf_data_q[i-1];
            end
            buf_v_q[0]    <= 1'b1;
            buf_addr_q[0] <= cap_addr_q;
            buf_data_q[0] <= {cap_hi_q, cap_lo_q};
        end
    end

    always_ff @(posedge clk) begin
        if (retire_w && !rst) begin
            mem[buf_addr_q[WB_DEPTH-1]] <= buf_data_q[WB_DEPTH-1];
        end
    end

    for (genvar g = 0; g < WB_DEPTH; g++) begin : g_hit
        assign hit_w[g] = buf_v_q[g] && (buf_addr_q[g] == pair_addr_i);
    end

    // coherent read: capture stage, then newest buffer slot, then array
    always_comb begin
        rd_pair_o = mem[pair_addr_i];
        for (int i = WB_DEPTH - 1; i >= 0; i--) begin
            if (hit_w[i]) begin
                rd_pair_o = buf_data_q[i];
            end
        end
        if (cap_v_q && (cap_addr_q == pair_addr_i)) begin
            rd_pair_o = {cap_hi_q, cap_lo_q};
        end
    end

    p_capture_follows_write_r3: assert property (@(posedge clk) disable iff (rst)
        st_is_write(state_i) |=> cap_v_q)
        else $error("write not captured");

    p_push_fills_r9: assert property (@(posedge clk) disable iff (rst)
        push_w |=> buf_v_q[0])
        else $error("completed write not buffered");

    if (WB_DEPTH > 1) begin : g_order_chk
        p_buf_order_r9: assert property (@(posedge clk) disable iff (rst)
            buf_v_q[WB_DEPTH-1] |-> buf_v_q[0])
            else $error("buffer holds a gap");
    end

endmodule

// File: rtl/dsr_bus_out.sv
module dsr_bus_out
    import ddr_sram_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  dsr_state_e      state_i,
    input  logic [2*DW-1:0] rd_pair_i,
    output logic [DW-1:0]   dq_o,
    output logic            dq_oe_o,
    output logic            cq_oe_o
);

    logic [2*DW-1:0] data_q;
    logic            dq_oe_q;
    logic            cq_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe_q <= 1'b0;
            cq_oe_q <= 1'b1;
        end else begin
            dq_oe_q <= st_is_read(state_i);
            cq_oe_q <= (state_i != ST_BANK_OFF);
        end
        if (st_is_read(state_i)) begin
            data_q <= rd_pair_i;
        end
    end

    // word 0 in the high phase, word 1 in the low phase
    assign dq_o    = clk ? data_q[DW-1:0] : data_q[2*DW-1:DW];
    assign dq_oe_o = dq_oe_q;
    assign cq_oe_o = cq_oe_q;

    p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
        st_is_read(state_i) |=> dq_oe_o)
        else $error("read did not drive bus");

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (st_is_write(state_i) || state_i == ST_IDLE || state_i == ST_BANK_OFF) |=> !dq_oe_o)
        else $error("bus not released");

    p_echo_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_IDLE) |=> cq_oe_o)
        else $error("echo clock stopped on idle");

    p_echo_off_r7: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_BANK_OFF) |=> !cq_oe_o)
        else $error("echo clock kept on bank-off");

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
    import ddr_sram_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int DW       = 8,
    parameter int WB_DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DEPTH/2)-1:0]   addr_i,
    input  logic                         ce_n_i,
    input  logic                         bank_sel_a_i,
    input  logic                         bank_sel_b_i,
    input  logic                         bank_pol_a_i,
    input  logic                         bank_pol_b_i,
    input  logic                         burst_next_i,
    input  logic                         we_n_i,
    input  logic [DW-1:0]                dq_i,
    output logic [DW-1:0]                dq_o,
    output logic                         dq_oe_o,
    output logic                         cq_oe_o
);

    localparam int AW = $clog2(DEPTH / 2);

    dsr_state_e      state_w;
    logic [AW-1:0]   pair_addr_w;
    logic [2*DW-1:0] rd_pair_w;

    dsr_cmd_fsm #(.AW(AW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .addr_i       (addr_i),
        .ce_n_i       (ce_n_i),
        .bank_sel_a_i (bank_sel_a_i),
        .bank_sel_b_i (bank_sel_b_i),
        .bank_pol_a_i (bank_pol_a_i),
        .bank_pol_b_i (bank_pol_b_i),
        .burst_next_i (burst_next_i),
        .we_n_i       (we_n_i),
        .state_o      (state_w),
        .pair_addr_o  (pair_addr_w)
    );

    dsr_store #(.AW(AW), .DW(DW), .WB_DEPTH(WB_DEPTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .state_i     (state_w),
        .pair_addr_i (pair_addr_w),
        .dq_i        (dq_i),
        .rd_pair_o   (rd_pair_w)
    );

    dsr_bus_out #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .state_i   (state_w),
        .rd_pair_i (rd_pair_w),
        .dq_o      (dq_o),
        .dq_oe_o   (dq_oe_o),
        .cq_oe_o   (cq_oe_o)
    );

endmodule

// File: tb/ddr_burst_sram_test.sv
module ddr_burst_sram_test;

    localparam int DEPTH = 64;
    localparam int DW    = 8;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          ce_n_i = 1'b1;
    logic          bank_sel_a_i = 1'b1;
    logic          bank_sel_b_i = 1'b0;
    logic          bank_pol_a_i = 1'b1;
    logic          bank_pol_b_i = 1'b0;
    logic          burst_next_i = 1'b0;
    logic          we_n_i = 1'b1;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;
    logic          cq_oe_o;

    always #5 clk = ~clk;

    ddr_burst_sram #(.DEPTH(DEPTH), .DW(DW), .WB_DEPTH(2)) uut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .ce_n_i(ce_n_i),
        .bank_sel_a_i(bank_sel_a_i), .bank_sel_b_i(bank_sel_b_i),
        .bank_pol_a_i(bank_pol_a_i), .bank_pol_b_i(bank_pol_b_i),
        .burst_next_i(burst_next_i), .we_n_i(we_n_i), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .cq_oe_o(cq_oe_o)
    );

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mem_model [int];

    // command model: 0 bank-off, 1 idle, 2 read, 3 write
    int            m_st = 1;
    logic [AW-1:0] m_base = '0;
    bit            m_flip = 1'b0;
    bit            g_pa = 1'b1;
    bit            g_pb = 1'b0;

    // expectations one and two commands back
    bit            e1_rd = 0, e2_rd = 0, e1_cq = 1, e2_cq = 1, e1_kn = 0, e2_kn = 0;
    logic [DW-1:0] e1_d0 = '0, e1_d1 = '0, e2_d0 = '0, e2_d1 = '0;
    string         e1_tag = "R10", e2_tag = "R10";
    logic [DW-1:0] p1_b0 = '0, p1_b1 = '0, p2_b1 = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dat(input int word, input int round);
        return DW'(word * 7 + round * 29 + 3);
    endfunction

    task automatic issue(input bit ce_n, input bit sa, input bit sb, input bit nxt,
                         input bit we_n, input logic [AW-1:0] a,
                         input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                         input string tag);
        bit            qual;
        bit            rd;
        bit            kn;
        logic [AW-1:0] pa;
        logic [DW-1:0] x0;
        logic [DW-1:0] x1;
        @(posedge clk);
        #1;
        ce_n_i = ce_n; bank_sel_a_i = sa; bank_sel_b_i = sb;
        bank_pol_a_i = g_pa; bank_pol_b_i = g_pb;
        burst_next_i = nxt; we_n_i = we_n; addr_i = a;
        dq_i = p2_b1;
        // model of the command sampled at the coming edge
        qual = (sa == g_pa) && (sb == g_pb);
        if (!nxt) begin
            m_flip = 1'b0;
            if (!qual) m_st = 0;
            else if (ce_n) m_st = 1;
            else begin
                m_base = a;
                m_st = we_n ? 2 : 3;
            end
        end else if (m_st >= 2) begin
            m_flip = ~m_flip;
        end
        pa = m_base ^ {{(AW-1){1'b0}}, m_flip};
        rd = (m_st == 2);
        kn = 0; x0 = '0; x1 = '0;
        if (m_st == 3) begin
            mem_model[int'(pa) * 2]     = d0;
            mem_model[int'(pa) * 2 + 1] = d1;
        end
        if (rd && mem_model.exists(int'(pa) * 2) && mem_model.exists(int'(pa) * 2 + 1)) begin
            kn = 1;
            x0 = mem_model[int'(pa) * 2];
            x1 = mem_model[int'(pa) * 2 + 1];
        end
        // outputs of the command two calls back, high phase
        #2;
        check(dq_oe_o == e2_rd, e2_tag, "dq_oe", int'(dq_oe_o), int'(e2_rd));
        check(cq_oe_o == e2_cq, e2_tag, "cq_oe", int'(cq_oe_o), int'(e2_cq));
        if (e2_rd && e2_kn)
            check(dq_o == e2_d0, e2_tag, "word0", int'(dq_o), int'(e2_d0));
        @(negedge clk);
        #1;
        dq_i = p1_b0;
        #2;
        if (e2_rd && e2_kn)
            check(dq_o == e2_d1, e2_tag, "word1", int'(dq_o), int'(e2_d1));
        e2_rd = e1_rd; e2_cq = e1_cq; e2_kn = e1_kn; e2_d0 = e1_d0; e2_d1 = e1_d1; e2_tag = e1_tag;
        e1_rd = rd; e1_cq = (m_st != 0); e1_kn = kn; e1_d0 = x0; e1_d1 = x1; e1_tag = tag;
        p2_b1 = p1_b1; p1_b0 = d0; p1_b1 = d1;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d0, input logic [DW-1:0] d1, input string tag);
        issue(0, g_pa, g_pb, 0, 0, AW'(a), d0, d1, tag);
    endtask
    task automatic rd_cmd(input int a, input string tag);
        issue(0, g_pa, g_pb, 0, 1, AW'(a), '0, '0, tag);
    endtask
    task automatic cont(input logic [DW-1:0] d0, input logic [DW-1:0] d1, input string tag);
        issue(0, g_pa, g_pb, 1, 0, '0, d0, d1, tag);
    endtask
    task automatic idle(input string tag);
        issue(1, g_pa, g_pb, 0, 1, '0, '0, '0, tag);
    endtask
    task automatic boff(input string tag);
        issue(0, ~g_pa, g_pb, 0, 1, '0, '0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        check(dq_oe_o == 1'b0, "R10", "reset dq_oe", int'(dq_oe_o), 0);
        check(cq_oe_o == 1'b1, "R10", "reset cq_oe", int'(cq_oe_o), 1);
        @(posedge clk);
        #1 rst = 1'b0;

        // R3, R4: burst writes fill every pair
        for (int p = 0; p < 32; p += 2) begin
            wr(p, dat(2 * p, 0), dat(2 * p + 1, 0), "R3");
            cont(dat(2 * (p ^ 1), 0), dat(2 * (p ^ 1) + 1, 0), "R4");
        end
        idle("R6");
        idle("R7");
        // R2, R4: read every pair with two continues (wrap)
        for (int p = 0; p < 32; p++) begin
            rd_cmd(p, "R2");
            cont('0, '0, "R4");
            cont('0, '0, "R4");
        end
        idle("R6");
        // R8: read right after a write, and one cycle later
        for (int p = 3; p < 32; p += 7) begin
            wr(p, dat(p, 5), dat(p, 6), "R6");
            rd_cmd(p, "R8");
            wr(p ^ 1, dat(p, 7), dat(p, 8), "R6");
            idle("R7");
            rd_cmd(p ^ 1, "R8");
        end
        // R9: four writes push through the buffer, read all back
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 4; k++) wr(8 + k, dat(k, 10 + r), dat(k + 1, 10 + r), "R6");
            for (int k = 0; k < 4; k++) rd_cmd(8 + k, "R9");
            rd_cmd(9, "R9");
        end
        // R5: continue after idle and bank-off writes nothing
        wr(20, dat(20, 40), dat(21, 40), "R6");
        idle("R7");
        cont(dat(1, 99), dat(2, 99), "R5");
        boff("R7");
        cont(dat(3, 99), dat(4, 99), "R5");
        rd_cmd(20, "R5");
        cont('0, '0, "R5");
        idle("R6");
        // R1: write with primary enable high stores nothing
        issue(1, g_pa, g_pb, 0, 0, AW'(21), dat(5, 77), dat(6, 77), "R1");
        rd_cmd(21, "R1");
        rd_cmd(20, "R1");
        // R11: every strap setting against every select combination
        for (int s = 0; s < 4; s++) begin
            g_pa = s[1];
            g_pb = s[0];
            idle("R11");
            for (int c = 0; c < 4; c++) begin
                issue(0, c[1], c[0], 0, 1, AW'(7), '0, '0, "R11");
                idle("R11");
            end
        end
        g_pa = 1'b1;
        g_pb = 1'b0;
        idle("R7");
        idle("R7");
        idle("R7");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule